// File: doc/BRIEF.md
# Periodic Time-Update Interrupt Generator

This block turns the once-per-second and once-per-minute roll-over ticks of a timekeeping core into a periodic interrupt event. A single select input picks which of the two ticks counts as the event. Each event sets a sticky status flag that software reads and later clears by writing a zero. The same event, when interrupts are enabled, starts a fixed-width request pulse that drives an active-low open-drain interrupt pin through an active-high pulldown-enable output.

The request pulse lasts a fixed number of slow reference ticks, 256 by default. With a 32.768 kHz reference that is close to 7.8 ms. A new event during the pulse starts the count again. The pulse releases itself and does not follow the flag. Clearing the flag leaves the pulse running. Dropping the enable bit ends the pulse at once.

All inputs are sampled on one system clock. The ticks, the reference tick and the flag write strobe are single-cycle strobes in that clock domain.

Top module: `upd_irq_gen`

## Requirements
- R1: The `src_minute` input picks the event source. With 0 each `sec_tick` strobe is an event and `min_tick` is ignored. With 1 each `min_tick` strobe is an event and `sec_tick` is ignored. The choice takes effect on the next tick.
- R2: An event sets `flag_q` to 1 on the next clock edge. The flag then holds 1 for as long as no clearing write arrives.
- R3: A flag write (`flag_wr`=1) with `flag_wdata`=0 clears `flag_q` on the next edge. A flag write with `flag_wdata`=1 leaves `flag_q` unchanged.
- R4: When an event and a clearing flag write fall in the same cycle, the event wins and `flag_q` is 1 after that edge.
- R5: `irq_pull` rises on the edge after an event only when `irq_en` is 1. When `irq_en` is 0, an event leaves `irq_pull` at 0.
- R6: Once started, `irq_pull` stays 1 through exactly `PULSE_TICKS` strobes of `ref_tick` and is 0 on the edge after the last of them.
- R7: A clearing flag write does not end an active `irq_pull`.
- R8: When `irq_en` is 0, `irq_pull` is 0 after the next edge, even if a pulse was active.
- R9: While `halt` or `soft_rst` is 1, ticks produce no event: `flag_q` is not set and `irq_pull` does not start.
- R10: An enabled event during an active pulse restarts the full `PULSE_TICKS` count.
- R11: After reset, `flag_q` and `irq_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe at each seconds roll-over |
| min_tick | input | 1 | One-cycle strobe at each minutes roll-over |
| ref_tick | input | 1 | One-cycle strobe from the slow pulse-timing reference |
| src_minute | input | 1 | Event source select: 0 selects seconds, 1 selects minutes |
| irq_en | input | 1 | Interrupt enable bit |
| halt | input | 1 | Stop bit; suppresses events |
| soft_rst | input | 1 | Software reset bit; suppresses events |
| flag_wr | input | 1 | Write strobe to the flag bit |
| flag_wdata | input | 1 | Value written to the flag bit |
| flag_q | output | 1 | Sticky update flag readback |
| irq_pull | output | 1 | Pulldown enable for the open-drain interrupt pin |

## Verification
Two functions can act in the same cycle: setting the flag on an event and clearing it on a software write. The bench raises `sec_tick` together with a flag write of zero, then judges the flag on the following edge, where it must read 1. A second collision pairs an enabled event with an already running pulse. There the bench counts reference ticks past the original end point and requires the pulldown to stay active until a full new count has elapsed.

// File: rtl/upd_irq_pkg.sv
package upd_irq_pkg;

  typedef enum logic {
    SRC_SECOND = 1'b0,
    SRC_MINUTE = 1'b1
  } upd_src_e;

  // Chooses the tick strobe that stands for an event under the given source.
  function automatic logic pick_tick(input upd_src_e src, input logic s_tick,
                                     input logic m_tick);
    return (src == SRC_MINUTE) ? m_tick : s_tick;
  endfunction

  // Events are blocked whenever either the stop or the software-reset bit is set.
  function automatic logic events_allowed(input logic stop_bit, input logic rst_bit);
    return !(stop_bit || rst_bit);
  endfunction

endpackage

// File: rtl/upd_event_sel.sv
module upd_event_sel
  import upd_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic min_tick,
  input  logic src_minute,
  input  logic halt,
  input  logic soft_rst,
  output logic evt
);

  upd_src_e src;
  logic     raw_tick;

  assign src      = upd_src_e'(src_minute);
  assign raw_tick = pick_tick(src, sec_tick, min_tick);
  assign evt      = raw_tick && events_allowed(halt, soft_rst);

  // R9: no event escapes while stopped or held in software reset
  a_r9_no_evt_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (halt || soft_rst) |-> !evt);

  // R1: an event always coincides with a strobe from the selected source
  a_r1_evt_from_source: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (src_minute ? min_tick : sec_tick));

endmodule

// File: rtl/upd_flag.sv
module upd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q
);

  logic clr_req;

  assign clr_req = flag_wr && !flag_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (evt)     flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  // R2 / R4: an event leaves the flag set, even alongside a clearing write
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);

  // R2: without a clearing write the flag is sticky
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);

  // R3: a clear write with no event empties the flag
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt) |=> !flag_q);

endmodule

// File: rtl/upd_pulse_timer.sv
module upd_pulse_timer #(
  parameter int PULSE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic irq_en,
  input  logic ref_tick,
  output logic irq_pull
);

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] cnt;
  logic             start;

  // Next count: load on an enabled event, drop on disable, step on reference ticks.
  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] cur,
                                                input logic ld, input logic en,
                                                input logic tk);
    if (ld)               return LOAD_VAL;
    if (!en)              return '0;
    if (tk && cur != '0)  return cur - 1'b1;
    return cur;
  endfunction

  assign start = evt && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_cnt(cnt, start, irq_en, ref_tick);
  end

  assign irq_pull = (cnt != '0);

  // R10: an enabled event reloads the full count
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == LOAD_VAL));

  // R8: disabling ends the request on the next edge
  a_r8_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_pull);

  // R5: the request cannot start without an enabled event
  a_r5_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pull && !start) |=> !irq_pull);

  // R6: without a reload the count never grows
  a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/upd_irq_gen.sv
module upd_irq_gen #(
  parameter int PULSE_TICKS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic min_tick,
  input  logic ref_tick,
  input  logic src_minute,
  input  logic irq_en,
  input  logic halt,
  input  logic soft_rst,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag_q,
  output logic irq_pull
);

  logic upd_evt;

  upd_event_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .min_tick   (min_tick),
    .src_minute (src_minute),
    .halt       (halt),
    .soft_rst   (soft_rst),
    .evt        (upd_evt)
  );

  upd_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (upd_evt),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .flag_q     (flag_q)
  );

  upd_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (upd_evt),
    .irq_en   (irq_en),
    .ref_tick (ref_tick),
    .irq_pull (irq_pull)
  );

  // R7: a clearing flag write alone never ends a running request
  a_r7_clear_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pull && irq_en && flag_wr && !flag_wdata && !ref_tick) |=> irq_pull);

endmodule

// File: tb/tb_upd_irq_gen.sv
`timescale 1ns/1ps
module tb_upd_irq_gen;

  localparam int PULSE = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, min_tick = 0, ref_tick = 0;
  logic src_minute = 0, irq_en = 0, halt = 0, soft_rst = 0;
  logic flag_wr = 0, flag_wdata = 0;
  logic flag_q, irq_pull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  upd_irq_gen #(.PULSE_TICKS(PULSE)) dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .min_tick(min_tick),
    .ref_tick(ref_tick), .src_minute(src_minute), .irq_en(irq_en),
    .halt(halt), .soft_rst(soft_rst), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .flag_q(flag_q), .irq_pull(irq_pull)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One cycle of strobes, then all strobes back to 0.
  task automatic strobe(input logic s, input logic m, input logic r,
                        input logic wr, input logic wd);
    sec_tick = s; min_tick = m; ref_tick = r; flag_wr = wr; flag_wdata = wd;
    step();
    sec_tick = 0; min_tick = 0; ref_tick = 0; flag_wr = 0; flag_wdata = 0;
  endtask

  task automatic clear_all();
    irq_en = 0; step(); strobe(0, 0, 0, 1, 0);
  endtask

  task automatic ref_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      strobe(0, 0, 1, 0, 0);
      step();
    end
  endtask

  task automatic t_reset();
    check(flag_q, 1'b0, "R11 flag after reset");
    check(irq_pull, 1'b0, "R11 irq after reset");
  endtask

  task automatic t_second_source();
    src_minute = 0; irq_en = 1;
    strobe(0, 1, 0, 0, 0);
    check(flag_q, 1'b0, "R1 minute tick ignored in second mode");
    check(irq_pull, 1'b0, "R1 no irq from minute tick");
    strobe(1, 0, 0, 0, 0);
    check(flag_q, 1'b1, "R2 flag set by second tick");
    check(irq_pull, 1'b1, "R5 irq starts when enabled");
    repeat (5) step();
    check(flag_q, 1'b1, "R2 flag holds");
    strobe(0, 0, 0, 1, 0);
    check(flag_q, 1'b0, "R3 write 0 clears flag");
    check(irq_pull, 1'b1, "R7 clearing flag keeps irq");
    strobe(0, 0, 0, 1, 1);
    check(flag_q, 1'b0, "R3 write 1 has no effect");
    irq_en = 0; step();
    check(irq_pull, 1'b0, "R8 disable releases irq");
  endtask

  task automatic t_minute_source();
    clear_all();
    src_minute = 1; irq_en = 1; step();
    strobe(1, 0, 0, 0, 0);
    check(flag_q, 1'b0, "R1 second tick ignored in minute mode");
    check(irq_pull, 1'b0, "R1 no irq from second tick");
    strobe(0, 1, 0, 0, 0);
    check(flag_q, 1'b1, "R1 minute tick sets flag");
    check(irq_pull, 1'b1, "R1 minute tick starts irq");
    src_minute = 0;
  endtask

  task automatic t_no_enable();
    clear_all();
    strobe(1, 0, 0, 0, 0);
    check(flag_q, 1'b1, "R5 flag set with enable 0");
    check(irq_pull, 1'b0, "R5 no irq with enable 0");
  endtask

  task automatic t_halt();
    clear_all();
    irq_en = 1; halt = 1;
    strobe(1, 0, 0, 0, 0);
    check(flag_q, 1'b0, "R9 halt blocks flag");
    check(irq_pull, 1'b0, "R9 halt blocks irq");
    halt = 0; soft_rst = 1;
    strobe(1, 0, 0, 0, 0);
    check(flag_q, 1'b0, "R9 soft reset blocks flag");
    check(irq_pull, 1'b0, "R9 soft reset blocks irq");
    soft_rst = 0;
  endtask

  task automatic t_collision();
    clear_all();
    strobe(1, 0, 0, 1, 0);
    check(flag_q, 1'b1, "R4 event wins over clear");
  endtask

  task automatic t_pulse_width();
    clear_all();
    irq_en = 1; step();
    strobe(1, 0, 0, 0, 0);
    check(irq_pull, 1'b1, "R6 pulse started");
    ref_ticks(PULSE - 1);
    check(irq_pull, 1'b1, "R6 still active before last tick");
    strobe(0, 0, 1, 0, 0);
    check(irq_pull, 1'b0, "R6 released after last tick");
  endtask

  task automatic t_restart();
    clear_all();
    irq_en = 1; step();
    strobe(1, 0, 0, 0, 0);
    ref_ticks(200);
    strobe(1, 0, 0, 0, 0);
    ref_ticks(PULSE - 1);
    check(irq_pull, 1'b1, "R10 restart extends pulse");
    strobe(0, 0, 1, 0, 0);
    check(irq_pull, 1'b0, "R10 restarted pulse ends after full count");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_second_source();
    t_minute_source();
    t_no_enable();
    t_halt();
    t_collision();
    t_pulse_width();
    t_restart();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule